// File: doc/BRIEF.md
# Permutation-Routed Layered Hash Network

This block evaluates a square network of hashing units: N layers with N units in each. Every unit of the first layer hashes the same input word. Each later layer takes the previous layer's outputs through a node-to-node permutation that is loaded at launch, and the same permutation is used between every pair of adjacent layers. The N outputs of the final layer are added as unsigned 32-bit values, and overflow wraps. The wrapped total is the digest.

The network is rolled. One pipelined mixing unit is shared by all N×N positions, and two ping-pong register banks hold a layer's results while the next layer reads them. The mixing unit is a small keyed add-rotate-xor function that stands in for a full cryptographic hash. Each unit is keyed by its own position within its layer, so the routing changes the digest.

A single-cycle start pulse captures the word, N and the permutation. The digest appears on a one-cycle valid pulse a fixed number of cycles later. It stays on the output until the next result replaces it.

Top module: `layered_hash_net`

## Requirements
- R1: While and after reset, and before any result, `valid_o` is 0 and `sum_o` is 0.
- R2: A unit with key j maps a word v through ROUNDS rounds (default 4). For r = 0, 1, …, round r computes a = v + (32'h9E3779B9 ^ (j << 8) ^ r) modulo 2^32, then sets v = rotate_left(a, 7) ^ a.
- R3: In the first layer, unit j (0 ≤ j < N) hashes `word_i` with key j.
- R4: The permutation field for node k sits at `perm_i[k*3 +: 3]` and holds dest(k). For every layer after the first, unit dest(k) hashes the previous layer's node-k output with key dest(k). The fields must form a permutation of 0..N-1.
- R5: The network has N layers. `sum_o` is the sum of the last layer's N outputs modulo 2^32.
- R6: An `n_i` of 0 is treated as 1. An `n_i` greater than NMAX (default 8) is treated as NMAX.
- R7: Permutation fields for node indices at or above the effective N have no effect on the result.
- R8: `valid_o` is high for exactly one cycle per result. `sum_o` keeps its value until the next result.
- R9: A start pulse that arrives while an evaluation is running is ignored. It produces no result and does not change the running one.
- R10: A start pulse in the same cycle that `valid_o` is high is accepted, and its result is computed correctly.
- R11: `valid_o` rises N×(N+ROUNDS+1) cycles after the clock edge that samples the accepted start, where N is the effective N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse, sampled only when idle |
| word_i | input | 32 | Word fed to every first-layer unit |
| n_i | input | 4 | Requested network size N |
| perm_i | input | NMAX*3 | Packed destination map, 3 bits per node |
| sum_o | output | 32 | Wrapping sum of the final layer |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
Two events can land in the same cycle: delivery of one digest on `valid_o`, and acceptance of the next launch. The bench waits for the cycle in which `valid_o` is high and drives `start_i` in that same cycle. It then checks the first digest against its expected value, and checks that the second evaluation produces its own expected digest at exactly the required latency, measured from that shared cycle. A start pulse sent in the middle of a run is also checked: it must produce no extra strobe, and the running result must be unchanged.

// File: rtl/lhn_pkg.sv
package lhn_pkg;

  localparam logic [31:0] KEY_BASE = 32'h9E3779B9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DRAIN
  } lhn_state_e;

  // one add-rotate-xor round, keyed by unit position and round number
  function automatic logic [31:0] mix_round(input logic [31:0] v,
                                            input logic [31:0] key,
                                            input int unsigned rnd);
    logic [31:0] a;
    a = v + (KEY_BASE ^ (key << 8) ^ 32'(rnd));
    return {a[24:0], a[31:25]} ^ a;
  endfunction

endpackage

// File: rtl/lhn_mix_pipe.sv
module lhn_mix_pipe #(
  parameter int ROUNDS = 4,
  parameter int TAGW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_v,
  input  logic [31:0]     in_data,
  input  logic [TAGW-1:0] in_tag,
  output logic            out_v,
  output logic [31:0]     out_data,
  output logic [TAGW-1:0] out_tag
);
  import lhn_pkg::*;

  logic            v_q [ROUNDS];
  logic [31:0]     d_q [ROUNDS];
  logic [TAGW-1:0] t_q [ROUNDS];

  logic            sv  [ROUNDS];
  logic [31:0]     sd  [ROUNDS];
  logic [TAGW-1:0] st  [ROUNDS];

  // stage inputs: stage 0 from the port, later stages from the previous register
  for (genvar i = 0; i < ROUNDS; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign sv[i] = in_v;
      assign sd[i] = in_data;
      assign st[i] = in_tag;
    end else begin : g_body
      assign sv[i] = v_q[i-1];
      assign sd[i] = d_q[i-1];
      assign st[i] = t_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ROUNDS; i++) begin
      if (rst) v_q[i] <= 1'b0;
      else     v_q[i] <= sv[i];
      d_q[i] <= mix_round(sd[i], 32'(st[i]), i);
      t_q[i] <= st[i];
    end
  end

  assign out_v    = v_q[ROUNDS-1];
  assign out_data = d_q[ROUNDS-1];
  assign out_tag  = t_q[ROUNDS-1];

endmodule

// File: rtl/lhn_bank.sv
module lhn_bank #(
  parameter int NMAX = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            we,
  input  logic            wsel,
  input  logic [IDXW-1:0] widx,
  input  logic [31:0]     wdata,
  input  logic            rsel,
  input  logic [IDXW-1:0] ridx,
  output logic [31:0]     rdata
);
  localparam int DEPTH = 2 * NMAX;
  localparam int AW    = $clog2(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] waddr, raddr;
  logic [31:0]   rdata_q;

  assign waddr = (wsel ? AW'(NMAX) : AW'(0)) + AW'(widx);
  assign raddr = (rsel ? AW'(NMAX) : AW'(0)) + AW'(ridx);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/lhn_ctrl.sv
module lhn_ctrl #(
  parameter int NMAX = 8,
  parameter int IDXW = 3,
  parameter int NW   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [31:0]          word_i,
  input  logic [NW-1:0]        n_i,
  input  logic [NMAX*IDXW-1:0] perm_i,
  input  logic [31:0]          rd_data,
  input  logic                 wb_v,
  input  logic [IDXW-1:0]      wb_idx,
  output logic                 rd_sel,
  output logic [IDXW-1:0]      rd_idx,
  output logic                 h_v,
  output logic [31:0]          h_data,
  output logic [IDXW-1:0]      h_tag,
  output logic                 acc_clr,
  output logic                 acc_en,
  output logic                 done
);
  import lhn_pkg::*;

  lhn_state_e      state_q;
  logic [NW-1:0]   n_q, layer_q, k_q, wcnt_q, n_eff;
  logic [31:0]     x_q;
  logic [IDXW-1:0] perm_q [NMAX];
  logic            sel_q;
  logic            s0_v, s0_first;
  logic [IDXW-1:0] s0_k;
  logic            accept, last_layer, layer_done;

  always_comb begin
    if (n_i == '0)                n_eff = NW'(1);
    else if (n_i > NW'(NMAX))     n_eff = NW'(NMAX);
    else                          n_eff = n_i;
  end

  assign accept     = (state_q == ST_IDLE) && start_i;
  assign last_layer = (layer_q == n_q - NW'(1));
  assign layer_done = wb_v && (wcnt_q == n_q - NW'(1));

  assign rd_sel  = sel_q;
  assign rd_idx  = k_q[IDXW-1:0];
  assign h_v     = s0_v;
  assign h_data  = s0_first ? x_q : rd_data;
  assign h_tag   = s0_first ? s0_k : perm_q[s0_k];
  assign acc_clr = accept;
  assign acc_en  = wb_v && last_layer;
  assign done    = layer_done && last_layer;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      n_q      <= NW'(1);
      layer_q  <= '0;
      k_q      <= '0;
      wcnt_q   <= '0;
      x_q      <= '0;
      sel_q    <= 1'b0;
      s0_v     <= 1'b0;
      s0_first <= 1'b0;
      s0_k     <= '0;
      for (int k = 0; k < NMAX; k++) perm_q[k] <= '0;
    end else begin
      s0_v     <= (state_q == ST_ISSUE);
      s0_k     <= k_q[IDXW-1:0];
      s0_first <= (layer_q == '0);
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            n_q     <= n_eff;
            x_q     <= word_i;
            layer_q <= '0;
            k_q     <= '0;
            wcnt_q  <= '0;
            sel_q   <= 1'b0;
            state_q <= ST_ISSUE;
            for (int k = 0; k < NMAX; k++) perm_q[k] <= perm_i[k*IDXW +: IDXW];
          end
        end
        ST_ISSUE: begin
          if (k_q == n_q - NW'(1)) state_q <= ST_DRAIN;
          k_q <= k_q + NW'(1);
        end
        default: ;
      endcase
      // writeback bookkeeping overrides the issue step at layer boundaries
      if (wb_v) begin
        if (layer_done) begin
          wcnt_q <= '0;
          if (last_layer) begin
            state_q <= ST_IDLE;
          end else begin
            layer_q <= layer_q + NW'(1);
            sel_q   <= ~sel_q;
            k_q     <= '0;
            state_q <= ST_ISSUE;
          end
        end else begin
          wcnt_q <= wcnt_q + NW'(1);
        end
      end
    end
  end

  // R9: a launch during a run leaves the captured operands alone
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && start_i) |=> ($stable(x_q) && $stable(n_q)));

  // R6: the captured size is always within 1..NMAX while running
  a_r6_n_in_range: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> (n_q >= NW'(1) && n_q <= NW'(NMAX)));

  // R4: every routed destination addresses a live unit
  a_r4_dest_in_range: assert property (@(posedge clk) disable iff (rst)
    h_v |-> (NW'(h_tag) < n_q));

  // R5: writebacks per layer never exceed N
  a_r5_wb_count: assert property (@(posedge clk) disable iff (rst)
    wb_v |-> (wcnt_q < n_q && NW'(wb_idx) < n_q));

endmodule

// File: rtl/layered_hash_net.sv
module layered_hash_net #(
  parameter int NMAX   = 8,
  parameter int ROUNDS = 4,
  parameter int IDXW   = $clog2(NMAX),
  parameter int NW     = $clog2(NMAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [31:0]          word_i,
  input  logic [NW-1:0]        n_i,
  input  logic [NMAX*IDXW-1:0] perm_i,
  output logic [31:0]          sum_o,
  output logic                 valid_o
);

  logic            rd_sel, h_v, wb_v, acc_clr, acc_en, done;
  logic [IDXW-1:0] rd_idx, h_tag, wb_idx;
  logic [31:0]     rd_data, h_data, wb_data;
  logic [31:0]     acc_q, sum_q;
  logic            valid_q;

  lhn_ctrl #(.NMAX(NMAX), .IDXW(IDXW), .NW(NW)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .word_i(word_i), .n_i(n_i),
    .perm_i(perm_i), .rd_data(rd_data), .wb_v(wb_v), .wb_idx(wb_idx),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .h_v(h_v), .h_data(h_data),
    .h_tag(h_tag), .acc_clr(acc_clr), .acc_en(acc_en), .done(done)
  );

  lhn_mix_pipe #(.ROUNDS(ROUNDS), .TAGW(IDXW)) u_mix (
    .clk(clk), .rst(rst), .in_v(h_v), .in_data(h_data), .in_tag(h_tag),
    .out_v(wb_v), .out_data(wb_data), .out_tag(wb_idx)
  );

  lhn_bank #(.NMAX(NMAX), .IDXW(IDXW)) u_bank (
    .clk(clk), .we(wb_v), .wsel(~rd_sel), .widx(wb_idx), .wdata(wb_data),
    .rsel(rd_sel), .ridx(rd_idx), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      sum_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= done;
      if (acc_clr)     acc_q <= '0;
      else if (acc_en) acc_q <= acc_q + wb_data;
      if (done) sum_q <= acc_q + wb_data;
    end
  end

  assign sum_o   = sum_q;
  assign valid_o = valid_q;

  // R8: the result strobe never lasts two cycles
  a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R8: the held digest changes only together with a strobe
  a_r8_sum_held: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(sum_o) || $past(rst));

endmodule

// File: tb/layered_hash_net_bench.sv
module layered_hash_net_bench;
  localparam int NMAX   = 8;
  localparam int ROUNDS = 4;
  localparam int IDXW   = 3;
  localparam int NW     = 4;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 start_i = 1'b0;
  logic [31:0]          word_i = '0;
  logic [NW-1:0]        n_i = '0;
  logic [NMAX*IDXW-1:0] perm_i = '0;
  logic [31:0]          sum_o;
  logic                 valid_o;

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  int     pm [8];

  logic [31:0] q_sum [$];
  longint      q_cyc [$];
  string       q_tag [$];

  layered_hash_net #(.NMAX(NMAX), .ROUNDS(ROUNDS)) u_layered_hash_net (
    .clk(clk), .rst(rst), .start_i(start_i), .word_i(word_i), .n_i(n_i),
    .perm_i(perm_i), .sum_o(sum_o), .valid_o(valid_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // R2 keyed mixing, computed from the requirement text
  function automatic logic [31:0] ref_hash(input logic [31:0] v, input int key);
    logic [31:0] a;
    for (int r = 0; r < ROUNDS; r++) begin
      a = v + (32'h9E3779B9 ^ (32'(key) << 8) ^ 32'(r));
      v = ((a << 7) | (a >> 25)) ^ a;
    end
    return v;
  endfunction

  function automatic int eff_n(input int n);
    if (n == 0) return 1;
    if (n > NMAX) return NMAX;
    return n;
  endfunction

  // R3, R4, R5 reference network
  function automatic logic [31:0] ref_net(input logic [31:0] x, input int n);
    logic [31:0] cur [NMAX];
    logic [31:0] nxt [NMAX];
    logic [31:0] s;
    int ne;
    ne = eff_n(n);
    for (int j = 0; j < ne; j++) cur[j] = ref_hash(x, j);
    for (int l = 1; l < ne; l++) begin
      for (int k = 0; k < ne; k++) nxt[pm[k]] = ref_hash(cur[k], pm[k]);
      for (int j = 0; j < ne; j++) cur[j] = nxt[j];
    end
    s = '0;
    for (int j = 0; j < ne; j++) s = s + cur[j];
    return s;
  endfunction

  // driver: launch one evaluation and queue its expected digest and strobe cycle
  task automatic launch(input logic [31:0] x, input int n, input string tag,
                        input bit now);
    int ne;
    if (!now) @(negedge clk);
    word_i = x;
    n_i = NW'(n);
    for (int k = 0; k < NMAX; k++) perm_i[k*IDXW +: IDXW] = pm[k][IDXW-1:0];
    start_i = 1'b1;
    @(posedge clk);
    #1;
    ne = eff_n(n);
    q_sum.push_back(ref_net(x, n));
    q_cyc.push_back(cyc + longint'(ne * (ne + ROUNDS + 1)));
    q_tag.push_back(tag);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (q_sum.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: scoreboard compare, strobe width and hold behaviour
  bit          prev_valid = 1'b0;
  bit          have_res = 1'b0;
  logic [31:0] last_sum = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o) begin
        check(!prev_valid, "R8", "strobe longer than one cycle", 32'(valid_o), 32'd0);
        if (q_sum.size() == 0) begin
          check(1'b0, "R9", "unexpected result strobe", sum_o, 32'd0);
        end else begin
          logic [31:0] es;
          longint ec;
          string tg;
          es = q_sum.pop_front();
          ec = q_cyc.pop_front();
          tg = q_tag.pop_front();
          check(sum_o === es, tg, "digest", sum_o, es);
          check(cyc == ec, "R11", "strobe cycle", 32'(cyc), 32'(ec));
        end
        last_sum = sum_o;
        have_res = 1'b1;
      end else if (have_res && prev_valid) begin
        check(sum_o === last_sum, "R8", "digest held after strobe", sum_o, last_sum);
      end
      prev_valid = valid_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not finish", 32'd0, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(valid_o === 1'b0, "R1", "valid in reset", 32'(valid_o), 32'd0);
    check(sum_o === 32'd0, "R1", "sum in reset", sum_o, 32'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0 && sum_o === 32'd0, "R1", "idle after reset", sum_o, 32'd0);

    // R2 R3: single unit network
    pm = '{0, 0, 0, 0, 0, 0, 0, 0};
    launch(32'h12345678, 1, "R2", 1'b0);
    wait_idle();

    // R3 R4: three layers, rotating map
    pm = '{2, 0, 1, 0, 0, 0, 0, 0};
    launch(32'hCAFEF00D, 3, "R4", 1'b0);
    wait_idle();

    // R7: same map with junk in the unused fields
    pm = '{2, 0, 1, 7, 6, 5, 7, 7};
    launch(32'hCAFEF00D, 3, "R7", 1'b0);
    wait_idle();

    // R4: five layers, scattered map
    pm = '{4, 1, 2, 0, 3, 0, 0, 0};
    launch(32'h0001DFAF, 5, "R4", 1'b0);
    wait_idle();

    // R5: full size network, reversed map, wrapping sum
    pm = '{7, 6, 5, 4, 3, 2, 1, 0};
    launch(32'hFFFFFFFF, 8, "R5", 1'b0);
    wait_idle();

    // R6: size zero and oversize requests
    pm = '{0, 1, 2, 3, 4, 5, 6, 7};
    launch(32'hA5A5A5A5, 0, "R6", 1'b0);
    wait_idle();
    pm = '{3, 0, 7, 1, 6, 2, 5, 4};
    launch(32'h5A5A0001, 12, "R6", 1'b0);
    wait_idle();

    // R9: second launch mid-run must be dropped
    pm = '{1, 3, 0, 2, 0, 0, 0, 0};
    launch(32'h00000042, 4, "R9", 1'b0);
    repeat (5) @(negedge clk);
    word_i = 32'hDEADBEEF;
    n_i = NW'(2);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    repeat (60) @(negedge clk);

    // R10: relaunch in the strobe cycle
    pm = '{1, 2, 0, 0, 0, 0, 0, 0};
    launch(32'h13579BDF, 3, "R10", 1'b0);
    @(negedge clk iff valid_o);
    pm = '{5, 0, 4, 1, 3, 2, 0, 0};
    launch(32'h2468ACE0, 6, "R10", 1'b1);
    wait_idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule